// File: doc/BRIEF.md
# EEPROM Page Write Buffer Controller

This block sits between a two-wire bus slave and a 4096 x 8 non-volatile array. A write command opens with a word address from the protocol controller. The bytes that follow are collected into a 32-entry page buffer, and only a stop condition commits them to the array in a self-timed write cycle. The write-cycle duration is a parameter given in clock cycles. While the cycle runs, `busy` is high. The protocol controller uses `busy` to withhold the acknowledge of its slave address, so the bus master can poll for completion.

Data bytes enter on a valid/ready stream. A byte moves on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while a command is open and collecting, from the cycle after `cmd_begin` until a stop, a restart or a commit. Outside that window the block applies back-pressure, and a byte offered there is neither taken nor stored. The producer must hold `wr_data` steady while `wr_valid` is high and `wr_ready` is low.

The write-protect input is watched over a window. The window opens on the clock edge that accepts the first data byte and closes when the write cycle ends. If protect is seen high before the commit, the command is dropped. If it is seen high during the cycle, the cycle stops at once and the page contents are undefined. The commit writes one byte per clock, in ascending in-page offset order. It writes only the offsets that received data.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, `busy`, `wr_ready` and `mem_we` are all low.
- R2: A `cmd_begin` pulse in the idle state latches `cmd_addr`. From the next cycle `wr_ready` is high, and each edge with `wr_valid` and `wr_ready` both high accepts one byte. While `wr_ready` is low, `wr_valid` has no effect.
- R3: The first byte goes to the in-page offset `cmd_addr[4:0]`. Each accepted byte advances the offset by one, wrapping from 31 to 0. Every commit address has `mem_addr[11:5]` equal to `cmd_addr[11:5]`.
- R4: If the command ends with `bus_restart` instead of `bus_stop`, no array write happens and `busy` stays low. The same holds for a command that receives no stop at all.
- R5: A `bus_stop` that ends a command with at least one byte, and with no protect seen, raises `busy` on the next cycle. `busy` then stays high for exactly WRITE_CYCLES cycles.
- R6: During the commit, `mem_we` pulses once for each offset that received data, in ascending offset order, one per cycle, beginning in the first busy cycle. Offsets that received no data are not written.
- R7: When more than 32 bytes are sent, later bytes overwrite earlier buffer entries. Each offset is written once, with the last value it received.
- R8: If `wp` is high on the edge that accepts the first byte, on any later edge before the stop, or on the stop edge itself, the command is cancelled. There is no `busy` and no write.
- R9: If `wp` is high during a busy cycle, `mem_we` is low in that cycle and `busy` falls on the next cycle. No further writes follow.
- R10: `wp` high between `cmd_begin` and the first accepted byte does not cancel the command.
- R11: While `busy` is high, `wr_ready` is low, and a `cmd_begin` is ignored. No command is open after the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_begin | input | 1 | Pulse: a write command opens with `cmd_addr` |
| cmd_addr | input | 12 | Word address of the write command |
| wr_valid | input | 1 | Data byte offered |
| wr_data | input | 8 | Data byte |
| wr_ready | output | 1 | Block is collecting and takes the byte |
| bus_stop | input | 1 | Pulse: stop condition seen on the bus |
| bus_restart | input | 1 | Pulse: repeated start seen on the bus |
| wp | input | 1 | Write protect, high protects the whole array |
| busy | output | 1 | Self-timed write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 12 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Two functions of this block can fall in one cycle: the stop-triggered commit and the protect check. A further coincidence is the last byte landing together with the stop, and the wrap of the offset onto an entry that already holds data. The bench drives `wp` high on exactly the stop edge, and expects no busy and no write. It raises `wp` in the middle of a running commit, and expects the write count to freeze at the cycles already spent and `busy` to drop one cycle later. Wrap and overflow are judged by rebuilding, in the bench, the expected offset order and last-written values, and comparing them with every logged array write.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PW_IDLE   = 2'd0,
    PW_FILL   = 2'd1,
    PW_COMMIT = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pwb_page_buffer.sv
module pwb_page_buffer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [ADDR_W-1:0]          load_addr,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic [PAGE_W-1:0]          rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  output logic [(1<<PAGE_W)-1:0]     filled,
  output logic [ADDR_W-PAGE_W-1:0]   page_hi
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] ptr;
  logic [DATA_W-1:0] slot [PAGE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      page_hi <= '0;
    end else if (load) begin
      ptr     <= load_addr[PAGE_W-1:0];
      page_hi <= load_addr[ADDR_W-1:PAGE_W];
    end else if (push) begin
      ptr     <= ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filled[i] <= 1'b0;
        slot[i]   <= '0;
      end else if (load) begin
        filled[i] <= 1'b0;
      end else if (push && ptr == PAGE_W'(i)) begin
        filled[i] <= 1'b1;
        slot[i]   <= push_data;
      end
    end
  end

  assign rd_data = slot[rd_idx];

  // R3: the upper address bits never move while bytes stream in
  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !load) |=> (page_hi == $past(page_hi)));

  // R3: the in-page offset steps by one with wrap
  assert_offset_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !load) |=> (ptr == PAGE_W'($past(ptr) + 1'b1)));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer #(
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   abort,
  input  logic [(1<<PAGE_W)-1:0] filled,
  output logic                   running,
  output logic                   done,
  output logic                   we,
  output logic [PAGE_W-1:0]      idx
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CYC_W = $clog2(WRITE_CYCLES + 1);

  logic [CYC_W-1:0] cnt;
  logic             last;
  logic             in_scan;

  assign last    = (cnt == CYC_W'(WRITE_CYCLES - 1));
  assign in_scan = (cnt < CYC_W'(PAGE));
  assign idx     = cnt[PAGE_W-1:0];
  assign we      = running && !abort && in_scan && filled[idx];
  assign done    = running && !abort && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (go) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (abort || last) running <= 1'b0;
      else               cnt     <= cnt + 1'b1;
    end
  end

  // R6: successive commit strobes go to strictly rising offsets
  assert_scan_rising_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we) && $past(running)) |-> (idx > $past(idx)));

  // R9: an abort ends the cycle on the next edge
  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && abort && !go) |=> !running);
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_begin,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              bus_stop,
  input  logic              bus_restart,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  import pwb_pkg::*;

  localparam int PAGE = 1 << PAGE_W;
  localparam int HI_W = ADDR_W - PAGE_W;

  pw_state_e         state, state_nx;
  logic              armed, cancel;
  logic              push, load, commit_go, close_fill;
  logic              cyc_done;
  logic [PAGE-1:0]   filled;
  logic [PAGE_W-1:0] scan_idx;
  logic [HI_W-1:0]   page_hi;

  assign wr_ready   = (state == PW_FILL);
  assign push       = wr_valid && wr_ready;
  assign close_fill = (state == PW_FILL) && (bus_stop || bus_restart);
  assign load       = cmd_begin && ((state == PW_IDLE) ||
                                    ((state == PW_FILL) && !close_fill));
  assign commit_go  = (state == PW_FILL) && bus_stop && !bus_restart &&
                      (armed || push) && !cancel && !wp;

  always_comb begin
    state_nx = state;
    unique case (state)
      PW_IDLE:   if (load) state_nx = PW_FILL;
      PW_FILL:   if (commit_go)       state_nx = PW_COMMIT;
                 else if (close_fill) state_nx = PW_IDLE;
      PW_COMMIT: if (cyc_done || wp)  state_nx = PW_IDLE;
      default:   state_nx = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PW_IDLE;
      armed  <= 1'b0;
      cancel <= 1'b0;
    end else begin
      state <= state_nx;
      if (load) begin
        armed  <= 1'b0;
        cancel <= 1'b0;
      end else if (state == PW_FILL) begin
        if (push)                   armed  <= 1'b1;
        if (wp && (armed || push))  cancel <= 1'b1;
      end
    end
  end

  pwb_page_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (cmd_addr),
    .push      (push),
    .push_data (wr_data),
    .rd_idx    (scan_idx),
    .rd_data   (mem_wdata),
    .filled    (filled),
    .page_hi   (page_hi)
  );

  pwb_commit_timer #(
    .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (commit_go),
    .abort   (wp),
    .filled  (filled),
    .running (busy),
    .done    (cyc_done),
    .we      (mem_we),
    .idx     (scan_idx)
  );

  assign mem_addr = {page_hi, scan_idx};

  // R11: no byte is taken while the write cycle runs
  assert_no_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  // R5: the write cycle only starts from a stop
  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  // R5: controller state and timer agree on the write cycle
  assert_state_matches_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_COMMIT) == busy);

  // R9: protect high blocks the array strobe
  assert_no_write_protected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!wp && busy));
endmodule

// File: tb/tb_eeprom_page_commit.sv
`timescale 1ns/100ps
module tb_eeprom_page_commit;
  localparam int WC = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_begin = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready;
  logic        bus_stop = 1'b0;
  logic        bus_restart = 1'b0;
  logic        wp = 1'b0;
  logic        busy;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;

  eeprom_page_commit #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .cmd_addr(cmd_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .bus_stop(bus_stop), .bus_restart(bus_restart), .wp(wp), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int          log_n = 0;
  logic [11:0] log_a [64];
  logic [7:0]  log_d [64];
  int          busy_cnt = 0;

  logic [7:0] exp_val [32];
  bit         exp_has [32];

  always @(negedge clk) begin
    if (mem_we && log_n < 64) begin
      log_a[log_n] = mem_addr;
      log_d[log_n] = mem_wdata;
      log_n = log_n + 1;
    end
    if (busy) busy_cnt = busy_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic clear_log();
    log_n = 0;
    busy_cnt = 0;
    for (int i = 0; i < 32; i++) begin
      exp_has[i] = 1'b0;
      exp_val[i] = '0;
    end
  endtask

  task automatic send_cmd(input logic [11:0] a);
    cmd_begin = 1'b1; cmd_addr = a;
    cyc();
    cmd_begin = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic [11:0] a, input int i);
    int o;
    wr_valid = 1'b1; wr_data = d;
    cyc();
    wr_valid = 1'b0;
    o = (int'(a[4:0]) + i) % 32;
    exp_val[o] = d;
    exp_has[o] = 1'b1;
  endtask

  task automatic pulse_stop();
    bus_stop = 1'b1;
    cyc();
    bus_stop = 1'b0;
  endtask

  task automatic compare_log(input logic [11:0] a, input string req);
    int j = 0;
    for (int o = 0; o < 32; o++) begin
      if (exp_has[o]) begin
        check(log_a[j] == {a[11:5], 5'(o)}, req, int'(log_a[j]), int'({a[11:5], 5'(o)}));
        check(log_d[j] == exp_val[o], req, int'(log_d[j]), int'(exp_val[o]));
        j++;
      end
    end
    check(log_n == j, req, log_n, j);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(wr_ready == 1'b0, "R1 wr_ready", int'(wr_ready), 0);
    check(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_page(input logic [11:0] a, input int n, input int seed, input string req);
    clear_log();
    send_cmd(a);
    @(negedge clk);
    check(wr_ready == 1'b1, "R2 ready after cmd", int'(wr_ready), 1);
    cyc();
    for (int i = 0; i < n; i++) push(8'(seed + i * 7), a, i);
    pulse_stop();
    @(negedge clk);
    check(busy == 1'b1, "R5 busy after stop", int'(busy), 1);
    repeat (WC + 6) cyc();
    check(busy_cnt == WC, "R5 busy length", busy_cnt, WC);
    compare_log(a, req);
  endtask

  task automatic t_restart();
    clear_log();
    send_cmd(12'h3A4);
    push(8'h11, 12'h3A4, 0);
    push(8'h22, 12'h3A4, 1);
    bus_restart = 1'b1; cyc(); bus_restart = 1'b0;
    repeat (4) cyc();
    pulse_stop();
    repeat (WC + 4) cyc();
    check(log_n == 0, "R4 restart no write", log_n, 0);
    check(busy_cnt == 0, "R4 restart no busy", busy_cnt, 0);
  endtask

  task automatic t_wp_on_stop();
    clear_log();
    send_cmd(12'h100);
    push(8'h5A, 12'h100, 0);
    wp = 1'b1; bus_stop = 1'b1;
    cyc();
    bus_stop = 1'b0; wp = 1'b0;
    repeat (WC + 4) cyc();
    check(log_n == 0, "R8 wp on stop edge write", log_n, 0);
    check(busy_cnt == 0, "R8 wp on stop edge busy", busy_cnt, 0);
  endtask

  task automatic t_wp_mid_fill();
    clear_log();
    send_cmd(12'h200);
    push(8'h01, 12'h200, 0);
    wp = 1'b1; cyc(); wp = 1'b0;
    push(8'h02, 12'h200, 1);
    pulse_stop();
    repeat (WC + 4) cyc();
    check(log_n == 0, "R8 wp mid fill write", log_n, 0);
    check(busy_cnt == 0, "R8 wp mid fill busy", busy_cnt, 0);
  endtask

  task automatic t_wp_before_first();
    clear_log();
    send_cmd(12'h7C2);
    wp = 1'b1; cyc(); wp = 1'b0;
    push(8'hC3, 12'h7C2, 0);
    push(8'h3C, 12'h7C2, 1);
    pulse_stop();
    repeat (WC + 4) cyc();
    check(busy_cnt == WC, "R10 write proceeds busy", busy_cnt, WC);
    compare_log(12'h7C2, "R10 write proceeds data");
  endtask

  task automatic t_wp_abort();
    int k = 0;
    clear_log();
    send_cmd(12'hA00);
    for (int i = 0; i < 32; i++) push(8'(i + 100), 12'hA00, i);
    pulse_stop();
    while (k < 10) begin
      @(negedge clk);
      if (busy) k++;
    end
    @(posedge clk); #1;
    wp = 1'b1;
    @(negedge clk);
    check(mem_we == 1'b0, "R9 strobe gated", int'(mem_we), 0);
    @(negedge clk);
    check(busy == 1'b0, "R9 busy drops", int'(busy), 1'b0);
    @(posedge clk); #1;
    wp = 1'b0;
    repeat (WC) cyc();
    check(log_n == 10, "R9 writes frozen", log_n, 10);
    check(busy_cnt == 11, "R9 busy cycles", busy_cnt, 11);
  endtask

  task automatic t_busy_ignores();
    clear_log();
    send_cmd(12'h040);
    push(8'h77, 12'h040, 0);
    pulse_stop();
    repeat (3) cyc();
    cmd_begin = 1'b1; cmd_addr = 12'hFFF; wr_valid = 1'b1; wr_data = 8'h99;
    @(negedge clk);
    check(wr_ready == 1'b0, "R11 no ready while busy", int'(wr_ready), 0);
    cyc();
    cmd_begin = 1'b0; wr_valid = 1'b0;
    repeat (WC + 4) cyc();
    @(negedge clk);
    check(wr_ready == 1'b0, "R11 cmd ignored", int'(wr_ready), 0);
    compare_log(12'h040, "R11 only first command");
  endtask

  initial begin
    t_reset();
    t_page(12'h000, 32, 3,  "R6 full page");
    t_page(12'h35E, 3,  40, "R3 wrap order");
    t_page(12'h8E4, 40, 9,  "R7 overflow last wins");
    t_page(12'hB07, 1,  200, "R6 single byte");
    t_restart();
    t_wp_on_stop();
    t_wp_mid_fill();
    t_wp_before_first();
    t_wp_abort();
    t_busy_ignores();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule